// File: doc/BRIEF.md
# Nibble-Wide A/D Converter Register Interface

This block sits between a 4-bit processor datapath and an external analog converter. The processor has two nibble registers, A and B. It issues one command per cycle on `cmdOp`. The block answers in the same cycle with the nibbles to load into A and B and with a skip decision. Commands that change state take effect at the next rising clock edge.

The converter can do two jobs. In conversion mode it produces a 10-bit sample. In comparator mode it compares the input against an 8-bit reference that the processor writes one nibble pair at a time. Bit 3 of the first control register selects the mode. The block pulses `convStart` to begin the job. The converter answers with a `convDone` pulse that carries the sample or the compare outcome. That pulse sets a completion flag. The processor polls the flag with a test command, which clears the flag when it reports it set. An input gate turns this test off.

Three 4-bit control registers are readable and writable through A.

Top module: `adcNibbleIf`

## Requirements
- R1: After reset the completion flag is 0, all control registers are 0 (so conversion mode is active), the result register is 0 and `cmpAbove` is 0.
- R2: Command codes on `cmdOp` are: 0 idle, 1 start, 2 read result, 3 read low bits, 4 write comparator, 5 test flag, 6 read control, 7 write control. Read control (6) places the register selected by `qSel` (0, 1 or 2) on `aOut` with `aWe`=1. Write control (7) loads `aIn` into that register. A `qSel` value of 3 reads 0 and writes nothing.
- R3: The mode is bit 3 of control register 0: 0 selects conversion, 1 selects comparator. `convCompare` shows that bit.
- R4: In conversion mode, read result gives `bOut`=result[9:6] and `aOut`=result[5:2], with `aWe`=`bWe`=1.
- R5: In comparator mode, read result gives `bOut`=result[7:4] and `aOut`=result[3:0], with `aWe`=`bWe`=1.
- R6: Read low bits gives `aOut`={result[1], result[0], 0, 0}, with `aWe`=1 and `bWe`=0.
- R7: In comparator mode, write comparator loads `bIn` into result[7:4] and `aIn` into result[3:0]. `cmpRef` shows result[7:0]. In conversion mode the command leaves the result register unchanged.
- R8: A start command drives `convStart`=1 in its own cycle and clears the completion flag.
- R9: `convDone` sets the completion flag. In conversion mode it also loads `convResult` into the result register. In comparator mode it latches `convOutcome` into `cmpAbove` and leaves the result register unchanged.
- R10: With `skipGate`=0, the test command gives `skip`=1 and clears the flag when the flag is 1. When the flag is 0 it gives `skip`=0.
- R11: With `skipGate`=1, the test command gives `skip`=0 and leaves the flag unchanged.
- R12: A start in the same cycle as `convDone` leaves the flag at 0. A test in the same cycle as `convDone` leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 4 | Command code for this cycle |
| qSel | input | 2 | Control register select |
| aIn | input | 4 | Current contents of register A |
| bIn | input | 4 | Current contents of register B |
| skipGate | input | 1 | 1 disables the flag test |
| convDone | input | 1 | Converter completion pulse |
| convResult | input | 10 | Conversion sample valid with convDone |
| convOutcome | input | 1 | Compare outcome valid with convDone |
| aOut | output | 4 | Value for register A |
| aWe | output | 1 | Load strobe for register A |
| bOut | output | 4 | Value for register B |
| bWe | output | 1 | Load strobe for register B |
| skip | output | 1 | Skip the next instruction |
| convStart | output | 1 | Begin conversion or compare |
| convCompare | output | 1 | Mode shown to the converter |
| cmpRef | output | 8 | Comparator reference |
| cmpAbove | output | 1 | Last compare outcome |

## Verification
Two flag updates can land on the same edge. A `convDone` pulse can coincide with a start command, or with a flag test. The bench drives each pair in one cycle. It then probes the flag with an ungated test in the next cycle: after a start the skip must be 0, and after a test the skip must be 1. It also checks that the test issued in the collision cycle still reported the flag's old value.

// File: rtl/adcNibblePkg.sv
package adcNibblePkg;
  localparam int NIB_W = 4;
  localparam int RES_W = 10;
  localparam int Q_COUNT = 3;
  localparam int SEL_W = 2;
  localparam int CMP_W = 2 * NIB_W;
  localparam int MODE_BIT = 3;

  typedef enum logic [3:0] {
    OP_IDLE  = 4'd0,
    OP_START = 4'd1,
    OP_RDRES = 4'd2,
    OP_RDLOW = 4'd3,
    OP_WRCMP = 4'd4,
    OP_TEST  = 4'd5,
    OP_RDQ   = 4'd6,
    OP_WRQ   = 4'd7
  } opT;

  typedef struct packed {
    logic start;
    logic rdRes;
    logic rdLow;
    logic wrCmp;
    logic rdQ;
    logic wrQ;
  } strobeT;
endpackage

// File: rtl/adcNibbleCtrl.sv
module adcNibbleCtrl
  import adcNibblePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cmdOp,
  input  logic       skipGate,
  input  logic       convDone,
  input  logic       modeCmp,
  output strobeT     strobes,
  output logic       skip,
  output logic       adfFlag
);
  opT op;
  logic isTest;

  always_comb begin
    op = opT'(cmdOp);
    strobes = '0;
    isTest = 1'b0;
    case (op)
      OP_START: strobes.start = 1'b1;
      OP_RDRES: strobes.rdRes = 1'b1;
      OP_RDLOW: strobes.rdLow = 1'b1;
      OP_WRCMP: strobes.wrCmp = modeCmp;
      OP_TEST:  isTest = 1'b1;
      OP_RDQ:   strobes.rdQ = 1'b1;
      OP_WRQ:   strobes.wrQ = 1'b1;
      default:  ;
    endcase
  end

  assign skip = isTest && !skipGate && adfFlag;

  // Priority: start clears, then done sets, then a taken skip clears.
  always_ff @(posedge clk) begin
    if (!rstN) adfFlag <= 1'b0;
    else if (strobes.start) adfFlag <= 1'b0;
    else if (convDone) adfFlag <= 1'b1;
    else if (skip) adfFlag <= 1'b0;
  end
endmodule

// File: rtl/adcNibbleDatapath.sv
module adcNibbleDatapath
  import adcNibblePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [SEL_W-1:0] qSel,
  input  logic [NIB_W-1:0] aIn,
  input  logic [NIB_W-1:0] bIn,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  input  logic             convOutcome,
  output logic [NIB_W-1:0] aOut,
  output logic             aWe,
  output logic [NIB_W-1:0] bOut,
  output logic             bWe,
  output logic             modeCmp,
  output logic [CMP_W-1:0] cmpRef,
  output logic             cmpAbove
);
  logic [NIB_W-1:0] qReg [Q_COUNT];
  logic [RES_W-1:0] adReg;
  logic [NIB_W-1:0] qRead;

  for (genvar g = 0; g < Q_COUNT; g++) begin : gQ
    always_ff @(posedge clk) begin
      if (!rstN) qReg[g] <= '0;
      else if (strobes.wrQ && qSel == SEL_W'(g)) qReg[g] <= aIn;
    end
  end

  assign modeCmp = qReg[0][MODE_BIT];
  assign cmpRef = adReg[CMP_W-1:0];

  always_comb begin
    qRead = '0;
    for (int i = 0; i < Q_COUNT; i++)
      if (qSel == SEL_W'(i)) qRead = qReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adReg <= '0;
      cmpAbove <= 1'b0;
    end else begin
      if (convDone && !modeCmp) adReg <= convResult;
      else if (strobes.wrCmp) adReg[CMP_W-1:0] <= {bIn, aIn};
      if (convDone && modeCmp) cmpAbove <= convOutcome;
    end
  end

  always_comb begin
    aOut = '0;
    bOut = '0;
    aWe = 1'b0;
    bWe = 1'b0;
    if (strobes.rdRes) begin
      aWe = 1'b1;
      bWe = 1'b1;
      if (modeCmp) begin
        bOut = adReg[2*NIB_W-1:NIB_W];
        aOut = adReg[NIB_W-1:0];
      end else begin
        bOut = adReg[RES_W-1:RES_W-NIB_W];
        aOut = adReg[RES_W-NIB_W-1:RES_W-2*NIB_W];
      end
    end else if (strobes.rdLow) begin
      aWe = 1'b1;
      aOut = {adReg[1:0], {(NIB_W-2){1'b0}}};
    end else if (strobes.rdQ) begin
      aWe = 1'b1;
      aOut = qRead;
    end
  end
endmodule

// File: rtl/adcNibbleIf.sv
module adcNibbleIf
  import adcNibblePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  cmdOp,
  input  logic [1:0]  qSel,
  input  logic [3:0]  aIn,
  input  logic [3:0]  bIn,
  input  logic        skipGate,
  input  logic        convDone,
  input  logic [9:0]  convResult,
  input  logic        convOutcome,
  output logic [3:0]  aOut,
  output logic        aWe,
  output logic [3:0]  bOut,
  output logic        bWe,
  output logic        skip,
  output logic        convStart,
  output logic        convCompare,
  output logic [7:0]  cmpRef,
  output logic        cmpAbove
);
  strobeT strobes;
  logic modeCmp;
  logic adfFlag;

  adcNibbleCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .skipGate(skipGate),
    .convDone(convDone), .modeCmp(modeCmp), .strobes(strobes),
    .skip(skip), .adfFlag(adfFlag)
  );

  adcNibbleDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .qSel(qSel),
    .aIn(aIn), .bIn(bIn), .convDone(convDone), .convResult(convResult),
    .convOutcome(convOutcome), .aOut(aOut), .aWe(aWe), .bOut(bOut),
    .bWe(bWe), .modeCmp(modeCmp), .cmpRef(cmpRef), .cmpAbove(cmpAbove)
  );

  assign convStart = strobes.start;
  assign convCompare = modeCmp;
endmodule

// File: rtl/adcNibbleChk.sv
module adcNibbleChk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cmdOp,
  input logic       skipGate,
  input logic       convDone,
  input logic       convCompare,
  input logic       skip,
  input logic [3:0] aOut,
  input logic       bWe,
  input logic       adfFlag,
  input logic [7:0] cmpRef
);
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 4'd1) |=> !adfFlag);

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && cmdOp != 4'd1) |=> adfFlag);

  assert_skip_only_on_test_R10: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> (cmdOp == 4'd5 && !skipGate));

  assert_gated_keeps_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 4'd5 && skipGate && !convDone) |=> adfFlag == $past(adfFlag));

  assert_low_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 4'd3) |-> (aOut[1:0] == 2'b00 && !bWe));

  assert_cmp_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 4'd4 && !convCompare && !convDone) |=> $stable(cmpRef));
endmodule

bind adcNibbleIf adcNibbleChk chk_i (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .skipGate(skipGate),
  .convDone(convDone), .convCompare(convCompare), .skip(skip),
  .aOut(aOut), .bWe(bWe), .adfFlag(adfFlag), .cmpRef(cmpRef)
);

// File: tb/adcNibbleIf_tb.sv
module adcNibbleIf_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [1:0] qSel = '0;
  logic [3:0] aIn = '0, bIn = '0;
  logic skipGate = 1'b0, convDone = 1'b0, convOutcome = 1'b0;
  logic [9:0] convResult = '0;
  logic [3:0] aOut, bOut;
  logic aWe, bWe, skip, convStart, convCompare, cmpAbove;
  logic [7:0] cmpRef;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  adcNibbleIf dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle; outputs settled 1 ns after the falling edge.
  task automatic cyc(input logic [3:0] op, input logic [3:0] a = 0,
                     input logic [3:0] b = 0, input logic [1:0] sel = 0,
                     input logic dn = 0, input logic [9:0] res = 0,
                     input logic oc = 0, input logic gt = 0);
    @(negedge clk);
    cmdOp = op; aIn = a; bIn = b; qSel = sel; convDone = dn;
    convResult = res; convOutcome = oc; skipGate = gt;
    #1;
  endtask

  task automatic probeFlag(input string req, input int exp);
    cyc(4'd5);
    chk(req, skip, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    cyc(4'd6, 0, 0, 0); chk("R1 q0", aOut, 0);
    chk("R1 mode", convCompare, 0);
    cyc(4'd2); chk("R1 resB", bOut, 0); chk("R1 resA", aOut, 0);
    chk("R1 cmpAbove", cmpAbove, 0);
    probeFlag("R1 flag", 0);

    // R2 control registers sweep (keep Q0 bit3 clear)
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 16; v++) begin
        logic [3:0] w;
        w = (s == 0) ? 4'(v & 7) : 4'(v);
        cyc(4'd7, w, 0, 2'(s));
        cyc(4'd6, 0, 0, 2'(s));
        chk("R2 rdq", aOut, (s == 3) ? 0 : int'(w));
        chk("R2 we", aWe, 1);
      end
    cyc(4'd6, 0, 0, 1); chk("R2 sel3 no write", aOut, 15);

    // R8/R9/R4/R6 conversion sweep
    for (int r = 0; r < 1024; r++) begin
      cyc(4'd1);
      chk("R8 start", convStart, 1); chk("R3 mode", convCompare, 0);
      cyc(4'd0, 0, 0, 0, 1, 10'(r));
      cyc(4'd2);
      chk("R4 b", bOut, r >> 6); chk("R4 a", aOut, (r >> 2) & 15);
      chk("R4 we", {aWe, bWe}, 3);
      cyc(4'd3);
      chk("R6 a", aOut, (r & 3) << 2); chk("R6 bwe", bWe, 0);
      if (r % 64 == 0) begin
        probeFlag("R10 set", 1);
        probeFlag("R10 cleared", 0);
      end
    end
    // last result 0x3FF; R7 ignored in conversion mode
    cyc(4'd4, 4'h0, 4'h0);
    chk("R7 ignored", cmpRef, 8'hFF);

    // R11 gated
    cyc(4'd0, 0, 0, 0, 1, 10'h3FF);
    cyc(4'd5, 0, 0, 0, 0, 0, 0, 1); chk("R11 skip0", skip, 0);
    probeFlag("R11 kept", 1);

    // R12 collisions
    cyc(4'd0, 0, 0, 0, 1, 10'h3FF);
    cyc(4'd1, 0, 0, 0, 1, 10'h3FF);
    probeFlag("R12 start wins", 0);
    cyc(4'd5, 0, 0, 0, 1, 10'h3FF); chk("R12 test old", skip, 0);
    probeFlag("R12 done wins", 1);
    cyc(4'd0, 0, 0, 0, 1, 10'h3FF);
    cyc(4'd5, 0, 0, 0, 1, 10'h3FF); chk("R12 test old1", skip, 1);
    probeFlag("R12 done over clear", 1);

    // R3/R5/R7 comparator mode
    cyc(4'd7, 4'h8, 0, 0);
    cyc(4'd0); chk("R3 cmp mode", convCompare, 1);
    for (int v = 0; v < 256; v++) begin
      cyc(4'd4, 4'(v & 15), 4'(v >> 4));
      cyc(4'd2);
      chk("R5 b", bOut, v >> 4); chk("R5 a", aOut, v & 15);
      chk("R7 ref", cmpRef, v);
    end
    // R9 compare done: outcome latched, result untouched
    cyc(4'd0, 0, 0, 0, 1, 10'h000, 1);
    cyc(4'd0); chk("R9 outcome", cmpAbove, 1); chk("R9 ref kept", cmpRef, 8'hFF);
    probeFlag("R9 flag cmp", 1);
    cyc(4'd0, 0, 0, 0, 1, 10'h000, 0);
    cyc(4'd0); chk("R9 outcome0", cmpAbove, 0);
    cyc(4'd4, 4'h5, 4'hA);
    cyc(4'd7, 4'h0, 0, 0);
    cyc(4'd2); chk("R7 top bits kept", bOut, 4'hE); chk("R4 a mixed", aOut, 4'h9);
    cyc(4'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule